// File: doc/BRIEF.md
# GPIO Port Register Bank with Configuration Lock

This block is the register side of a 16-pin general-purpose I/O port. A 32-bit register bus with a word index reaches it. For each pin it stores a direction mode, an output type, a speed code, a pull code and a 4-bit alternate-function index. From these it drives abstract pad controls: output enable, pad data, an open-drain flag, pull-up and pull-down selects, and the function index. Pad inputs pass through a two-flop synchronizer into a read-only input register.

Output data can be written whole through a data register. It can also be changed atomically through a write-only set/clear register, so software never needs a read-modify-write. A three-step key sequence on a lock register freezes the configuration of the selected pins until the next reset. Output data stays writable after the lock.

Register word indices are 0 mode, 1 output type, 2 speed, 3 pull, 4 input (read-only), 5 output data, 6 set/clear (write-only), 7 lock, 8 function low, 9 function high.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads zero and pad_oe, pad_od, pad_pu and pad_pd are all zero, so every pin is a floating input.
- R2: Pin i's mode is field [2i+1:2i] of word 0 (00 input, 01 output, 10 function, 11 analog). pad_oe can be 1 only in mode 01 or 10. The mode, type, speed and pull registers read back what was written.
- R3: In push-pull output mode the pad data equals the output data bit written at word 5. In function mode the pad data is the pin's alt_dout bit.
- R4: A write to word 6 sets output bits where bits 15:0 are 1 and clears them where bits 31:16 are 1. Zero bits leave bits unchanged. Word 6 reads as zero.
- R5: When set bit i and clear bit i+16 are both 1 in one write, the output bit ends at 1.
- R6: With output type bit i = 1 (word 1), pad_od[i] is 1 and pad_dout[i] is 0. pad_oe[i] is 1 only while the pin's data is 0.
- R7: Pull field [2i+1:2i] of word 3: 01 asserts pad_pu[i], 10 asserts pad_pd[i], and 00 or 11 asserts neither.
- R8: The function index of pins 0-7 sits in word 8 and that of pins 8-15 in word 9, at bit offset (i mod 8)*4. It appears at pad_af_sel[4i+3:4i].
- R9: A pad_in change shows in word 4 only after two rising clock edges.
- R10: Three writes to word 7 lock the pins in mask bits 15:0. The writes carry key bit 16 = 1, then 0, then 1, with the same mask each time. Afterwards word 7 reads key=1 with the locked mask.
- R11: The mode, type, speed, pull and both function fields of locked pins ignore writes until reset. Unlocked pins and the output data stay writable.
- R12: A key out of order or a changed mask sends the sequence back to its first step without locking. Once locked, further writes to word 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 16 | Pad input levels |
| alt_dout | input | 16 | Data from alternate-function peripherals |
| pad_oe | output | 16 | Pad output enable |
| pad_dout | output | 16 | Pad output data |
| pad_od | output | 16 | Open-drain flag |
| pad_pu | output | 16 | Pull-up select |
| pad_pd | output | 16 | Pull-down select |
| pad_af_sel | output | 64 | Function index, 4 bits per pin |

## Verification
The assertions take three things for granted. Writes arrive as single-cycle strobes with a stable index and data. A lock, once taken, is released only by reset. The mode field is the only thing that decides whether a pad may drive. The directed stimulus drives the bus away from the clock edge and pulses bus_wr for exactly one cycle. It leaves the lock cases for the end of a scenario and applies a fresh reset before each scenario, so no assertion sees a lock removed except through reset.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types for the GPIO port register bank.
// Assumes a word-indexed register bus; indices are fixed here.
package gpio_port_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] IDX_MODE   = 4'd0;
    localparam logic [ADDR_W-1:0] IDX_OTYPE  = 4'd1;
    localparam logic [ADDR_W-1:0] IDX_SPEED  = 4'd2;
    localparam logic [ADDR_W-1:0] IDX_PULL   = 4'd3;
    localparam logic [ADDR_W-1:0] IDX_IN     = 4'd4;
    localparam logic [ADDR_W-1:0] IDX_OUT    = 4'd5;
    localparam logic [ADDR_W-1:0] IDX_SETCLR = 4'd6;
    localparam logic [ADDR_W-1:0] IDX_LOCK   = 4'd7;
    localparam logic [ADDR_W-1:0] IDX_AF_LO  = 4'd8;
    localparam logic [ADDR_W-1:0] IDX_AF_HI  = 4'd9;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_OUTPUT = 2'b01,
        PM_ALT    = 2'b10,
        PM_ANALOG = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        LK_WAIT_SET1 = 2'd0,
        LK_WAIT_CLR  = 2'd1,
        LK_WAIT_SET2 = 2'd2,
        LK_ACTIVE    = 2'd3
    } lock_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the pad input levels.
// Assumes each bit is sampled independently; no cross-bit coherence.
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;

    // Purpose: two register stages to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            sync_out <= '0;
        end else begin
            stage1_q <= async_in;
            sync_out <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_lock_seq.sv
// Key-sequence tracker for the configuration lock.
// Expects writes carrying key=1, key=0, key=1 with one mask. Any other
// write returns it to the first step. Once active it holds until reset.
module gpio_lock_seq
    import gpio_port_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            key,
    input  logic [PINS-1:0] mask,
    output logic            lock_on,
    output logic [PINS-1:0] lock_mask
);
    lock_state_e     state_q;
    logic [PINS-1:0] mask_q;

    // Purpose: advance the key sequence on each lock-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_WAIT_SET1;
            mask_q  <= '0;
        end else if (wr_en) begin
            unique case (state_q)
                LK_WAIT_SET1: begin
                    if (key) begin
                        state_q <= LK_WAIT_CLR;
                        mask_q  <= mask;
                    end
                end
                LK_WAIT_CLR:
                    state_q <= (!key && mask == mask_q) ? LK_WAIT_SET2 : LK_WAIT_SET1;
                LK_WAIT_SET2:
                    state_q <= (key && mask == mask_q) ? LK_ACTIVE : LK_WAIT_SET1;
                LK_ACTIVE: state_q <= LK_ACTIVE;
            endcase
        end
    end

    // Purpose: expose the mask only once the lock has taken effect.
    always_comb begin
        lock_on   = (state_q == LK_ACTIVE);
        lock_mask = lock_on ? mask_q : '0;
    end
endmodule

// File: rtl/gpio_pad_map.sv
// Per-pin translation of configuration into abstract pad controls.
// Assumes the pad applies pulls itself; analog mode simply disables drive.
module gpio_pad_map
    import gpio_port_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic [2*PINS-1:0] mode,
    input  logic [PINS-1:0]   otype,
    input  logic [2*PINS-1:0] pull,
    input  logic [4*PINS-1:0] af,
    input  logic [PINS-1:0]   out_data,
    input  logic [PINS-1:0]   alt_dout,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_dout,
    output logic [PINS-1:0]   pad_od,
    output logic [PINS-1:0]   pad_pu,
    output logic [PINS-1:0]   pad_pd,
    output logic [4*PINS-1:0] pad_af_sel
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pin_mode_e pm;
        logic      drive_en;
        logic      src;

        // Purpose: derive drive enable, data and pull selects for one pin.
        always_comb begin
            pm          = pin_mode_e'(mode[2*i +: 2]);
            drive_en    = (pm == PM_OUTPUT) || (pm == PM_ALT);
            src         = (pm == PM_ALT) ? alt_dout[i] : out_data[i];
            pad_od[i]   = otype[i];
            pad_oe[i]   = drive_en && (!otype[i] || !src);
            pad_dout[i] = otype[i] ? 1'b0 : src;
            pad_pu[i]   = (pull[2*i +: 2] == 2'b01);
            pad_pd[i]   = (pull[2*i +: 2] == 2'b10);
        end
    end

    assign pad_af_sel = af;
endmodule

// File: rtl/gpio_port_regs.sv
// GPIO port register bank: per-pin configuration, output data with
// atomic set/clear, synchronized input and a configuration lock.
// Assumes PINS = 16 so that set and clear halves fit one 32-bit word.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [PINS-1:0]     pad_in,
    input  logic [PINS-1:0]     alt_dout,
    output logic [PINS-1:0]     pad_oe,
    output logic [PINS-1:0]     pad_dout,
    output logic [PINS-1:0]     pad_od,
    output logic [PINS-1:0]     pad_pu,
    output logic [PINS-1:0]     pad_pd,
    output logic [4*PINS-1:0]   pad_af_sel
);
    localparam int W2   = 2 * PINS;
    localparam int W4   = 4 * PINS;
    localparam int HALF = W4 / 2;

    logic [W2-1:0]   mode_q, speed_q, pull_q;
    logic [PINS-1:0] otype_q, out_q, in_sync;
    logic [W4-1:0]   af_q;
    logic            lock_on;
    logic [PINS-1:0] lock_mask;
    logic [W2-1:0]   keep2;
    logic [W4-1:0]   keep4;
    logic            we_mode, we_otype, we_speed, we_pull;
    logic            we_out, we_setclr, we_lock, we_aflo, we_afhi;

    // Purpose: decode one write strobe per register word.
    always_comb begin
        we_mode   = bus_wr && bus_addr == IDX_MODE;
        we_otype  = bus_wr && bus_addr == IDX_OTYPE;
        we_speed  = bus_wr && bus_addr == IDX_SPEED;
        we_pull   = bus_wr && bus_addr == IDX_PULL;
        we_out    = bus_wr && bus_addr == IDX_OUT;
        we_setclr = bus_wr && bus_addr == IDX_SETCLR;
        we_lock   = bus_wr && bus_addr == IDX_LOCK;
        we_aflo   = bus_wr && bus_addr == IDX_AF_LO;
        we_afhi   = bus_wr && bus_addr == IDX_AF_HI;
    end

    // Spread the per-pin lock mask across 2-bit and 4-bit fields.
    for (genvar i = 0; i < PINS; i++) begin : g_keep
        assign keep2[2*i +: 2] = {2{lock_mask[i]}};
        assign keep4[4*i +: 4] = {4{lock_mask[i]}};
    end

    // Purpose: configuration registers; locked fields keep their value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            otype_q <= '0;
            speed_q <= '0;
            pull_q  <= '0;
            af_q    <= '0;
        end else begin
            if (we_mode)  mode_q  <= (bus_wdata[W2-1:0] & ~keep2) | (mode_q & keep2);
            if (we_otype) otype_q <= (bus_wdata[PINS-1:0] & ~lock_mask) | (otype_q & lock_mask);
            if (we_speed) speed_q <= (bus_wdata[W2-1:0] & ~keep2) | (speed_q & keep2);
            if (we_pull)  pull_q  <= (bus_wdata[W2-1:0] & ~keep2) | (pull_q & keep2);
            if (we_aflo)
                af_q[HALF-1:0] <= (bus_wdata[HALF-1:0] & ~keep4[HALF-1:0])
                                | (af_q[HALF-1:0] & keep4[HALF-1:0]);
            if (we_afhi)
                af_q[W4-1:HALF] <= (bus_wdata[HALF-1:0] & ~keep4[W4-1:HALF])
                                 | (af_q[W4-1:HALF] & keep4[W4-1:HALF]);
        end
    end

    // Purpose: output data, written whole or via set/clear (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (we_out)
            out_q <= bus_wdata[PINS-1:0];
        else if (we_setclr)
            out_q <= (out_q & ~bus_wdata[2*PINS-1:PINS]) | bus_wdata[PINS-1:0];
    end

    // Purpose: combinational read mux; write-only and unused words read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            IDX_MODE:  bus_rdata[W2-1:0]   = mode_q;
            IDX_OTYPE: bus_rdata[PINS-1:0] = otype_q;
            IDX_SPEED: bus_rdata[W2-1:0]   = speed_q;
            IDX_PULL:  bus_rdata[W2-1:0]   = pull_q;
            IDX_IN:    bus_rdata[PINS-1:0] = in_sync;
            IDX_OUT:   bus_rdata[PINS-1:0] = out_q;
            IDX_LOCK:  bus_rdata[PINS:0]   = {lock_on, lock_mask};
            IDX_AF_LO: bus_rdata[HALF-1:0] = af_q[HALF-1:0];
            IDX_AF_HI: bus_rdata[HALF-1:0] = af_q[W4-1:HALF];
            default:   bus_rdata = '0;
        endcase
    end

    gpio_in_sync #(.W(PINS)) i_in_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    gpio_lock_seq #(.PINS(PINS)) i_lock_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (we_lock),
        .key       (bus_wdata[PINS]),
        .mask      (bus_wdata[PINS-1:0]),
        .lock_on   (lock_on),
        .lock_mask (lock_mask)
    );

    gpio_pad_map #(.PINS(PINS)) i_pad_map (
        .mode       (mode_q),
        .otype      (otype_q),
        .pull       (pull_q),
        .af         (af_q),
        .out_data   (out_q),
        .alt_dout   (alt_dout),
        .pad_oe     (pad_oe),
        .pad_dout   (pad_dout),
        .pad_od     (pad_od),
        .pad_pu     (pad_pu),
        .pad_pd     (pad_pd),
        .pad_af_sel (pad_af_sel)
    );
endmodule

// File: rtl/gpio_port_checker.sv
// Assertion checker for gpio_port_regs, attached by bind below.
// Assumes single-cycle write strobes and a lock cleared only by reset.
module gpio_port_checker
    import gpio_port_pkg::*;
#(
    parameter int PINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [2*PINS-1:0] mode_q,
    input logic [PINS-1:0]   out_q,
    input logic              lock_on,
    input logic [PINS-1:0]   lock_mask,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_od,
    input logic [PINS-1:0]   pad_dout
);
    logic [2*PINS-1:0] held2;
    logic [PINS-1:0]   may_drive;

    // Purpose: reference views of lock coverage and drive permission.
    always_comb begin
        for (int i = 0; i < PINS; i++) begin
            held2[2*i +: 2] = {2{lock_mask[i]}};
            may_drive[i]    = (mode_q[2*i +: 2] == 2'b01) || (mode_q[2*i +: 2] == 2'b10);
        end
    end

    p_oe_needs_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~may_drive) == '0);

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_SETCLR) |=>
            ((out_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

    p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_od & pad_dout) == '0);

    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_on |=> (lock_on && $stable(lock_mask)));

    p_locked_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_on |=> (((mode_q ^ $past(mode_q)) & held2) == '0));
endmodule

bind gpio_port_regs gpio_port_checker #(.PINS(PINS)) i_gpio_port_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mode_q    (mode_q),
    .out_q     (out_q),
    .lock_on   (lock_on),
    .lock_mask (lock_mask),
    .pad_oe    (pad_oe),
    .pad_od    (pad_od),
    .pad_dout  (pad_dout)
);

// File: tb/test_gpio_port_regs.sv
// Directed bench for gpio_port_regs: one task per scenario.
module test_gpio_port_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] alt_dout = '0;
    logic [15:0] pad_oe, pad_dout, pad_od, pad_pu, pad_pd;
    logic [63:0] pad_af_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_regs i_gpio_port_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .alt_dout(alt_dout), .pad_oe(pad_oe), .pad_dout(pad_dout),
        .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_af_sel(pad_af_sel)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int a = 0; a < 10; a++) begin
            rd(a[3:0], v);
            chk($sformatf("R1 reg%0d", a), {32'b0, v}, 64'h0);
        end
        chk("R1 pads", {pad_oe, pad_od, pad_pu, pad_pd}, 64'h0);
    endtask

    task automatic t_mode_drive();
        logic [31:0] v;
        do_reset();
        wr(4'd0, 32'h0000_00E4);
        wr(4'd5, 32'h0000_FFFF);
        alt_dout = 16'h0000;
        #1;
        chk("R2 oe only out/alt", {48'b0, pad_oe}, 64'h0006);
        chk("R3 push-pull data", {48'b0, pad_dout & pad_oe}, 64'h0002);
        alt_dout = 16'hFFFF;
        #1;
        chk("R3 alt data", {48'b0, pad_dout & pad_oe}, 64'h0006);
        alt_dout = 16'h0000;
        wr(4'd2, 32'hAAAA_5555);
        rd(4'd2, v);
        chk("R2 speed readback", {32'b0, v}, 64'hAAAA_5555);
        rd(4'd0, v);
        chk("R2 mode readback", {32'b0, v}, 64'h0000_00E4);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        do_reset();
        wr(4'd5, 32'h0000_00F0);
        wr(4'd6, 32'h0003_000F);
        rd(4'd5, v);
        chk("R5 set wins", {32'b0, v}, 64'h0000_00FF);
        wr(4'd6, 32'h00F0_0000);
        rd(4'd5, v);
        chk("R4 clear only", {32'b0, v}, 64'h0000_000F);
        wr(4'd6, 32'h0000_0000);
        rd(4'd5, v);
        chk("R4 zero no change", {32'b0, v}, 64'h0000_000F);
        rd(4'd6, v);
        chk("R4 setclr reads zero", {32'b0, v}, 64'h0);
    endtask

    task automatic t_open_drain();
        do_reset();
        wr(4'd0, 32'h5555_5555);
        wr(4'd1, 32'h0000_000F);
        wr(4'd5, 32'h0000_0005);
        #1;
        chk("R6 od flag", {48'b0, pad_od}, 64'h000F);
        chk("R6 oe low only", {48'b0, pad_oe}, 64'hFFFA);
        chk("R6 dout", {48'b0, pad_dout}, 64'h0000);
        wr(4'd5, 32'h0000_FFFF);
        #1;
        chk("R6 released", {48'b0, pad_oe}, 64'hFFF0);
        chk("R6 dout high", {48'b0, pad_dout}, 64'hFFF0);
    endtask

    task automatic t_pull_af();
        do_reset();
        wr(4'd3, 32'h0000_0039);
        #1;
        chk("R7 pull up", {48'b0, pad_pu}, 64'h0001);
        chk("R7 pull down", {48'b0, pad_pd}, 64'h0002);
        wr(4'd8, 32'h7654_3210);
        wr(4'd9, 32'hFEDC_BA98);
        #1;
        chk("R8 af all", pad_af_sel, 64'hFEDC_BA98_7654_3210);
        chk("R8 pin9 field", {60'b0, pad_af_sel[39:36]}, 64'h9);
    endtask

    task automatic t_input_sync();
        logic [31:0] v;
        do_reset();
        @(negedge clk);
        pad_in = 16'hA5C3;
        @(negedge clk);
        rd(4'd4, v);
        chk("R9 one edge", {32'b0, v}, 64'h0);
        @(negedge clk);
        rd(4'd4, v);
        chk("R9 two edges", {32'b0, v}, 64'hA5C3);
        pad_in = '0;
    endtask

    task automatic t_lock_abort();
        logic [31:0] v;
        do_reset();
        wr(4'd7, 32'h0000_0001);
        wr(4'd7, 32'h0001_0003);
        wr(4'd7, 32'h0000_0001);
        wr(4'd7, 32'h0001_0003);
        rd(4'd7, v);
        chk("R12 bad mask no lock", {32'b0, v}, 64'h0);
        wr(4'd7, 32'h0000_0003);
        wr(4'd7, 32'h0001_0003);
        rd(4'd7, v);
        chk("R12 restart then lock", {32'b0, v}, 64'h0001_0003);
    endtask

    task automatic t_lock_freeze();
        logic [31:0] v;
        do_reset();
        wr(4'd7, 32'h0001_00F0);
        wr(4'd7, 32'h0000_00F0);
        wr(4'd7, 32'h0001_00F0);
        rd(4'd7, v);
        chk("R10 key and mask", {32'b0, v}, 64'h0001_00F0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v);
        chk("R11 mode frozen", {32'b0, v}, 64'hFFFF_00FF);
        wr(4'd1, 32'h0000_FFFF);
        rd(4'd1, v);
        chk("R11 otype frozen", {32'b0, v}, 64'h0000_FF0F);
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, v);
        chk("R11 pull frozen", {32'b0, v}, 64'hFFFF_00FF);
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, v);
        chk("R11 af lo frozen", {32'b0, v}, 64'h0000_FFFF);
        wr(4'd5, 32'h0000_1234);
        rd(4'd5, v);
        chk("R11 out still writable", {32'b0, v}, 64'h0000_1234);
        wr(4'd7, 32'h0001_FFFF);
        wr(4'd7, 32'h0000_FFFF);
        wr(4'd7, 32'h0001_FFFF);
        rd(4'd7, v);
        chk("R12 relock ignored", {32'b0, v}, 64'h0001_00F0);
    endtask

    initial begin
        t_reset();
        t_mode_drive();
        t_setclr();
        t_open_drain();
        t_pull_af();
        t_input_sync();
        t_lock_abort();
        t_lock_freeze();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule